// File: doc/BRIEF.md
# Miner Control Register File

This block is the register-mapped front end of a hashing engine. An external controller talks to it over a simple word bus. The bus has an 8-bit word address, 32-bit write data, a write strobe, a read strobe, and 32-bit read data that is registered. Through this bus the controller can do four things. It reads identification words. It stages a job in a 1024-bit job pad and commits the job to a job queue. It pulls found results out of a result queue into a result pad. It also watches the engine's nonce and activity, and can park the engine.

The job queue feeds the dispatcher over a valid/ready stream. `job_valid` is high while the queue holds an entry, `job_data` is the oldest entry, and an entry leaves on a clock edge where both `job_valid` and `job_ready` are high. The result queue takes results over a second valid/ready stream. `res_ready` is low while the queue is full, and a result is stored only on an edge where `res_valid` and `res_ready` are both high. A sender must hold `res_data` steady until that edge. Some bus writes trigger actions: a write to the control word can commit a job or pop a result, and a write to the queue word can flush either queue.

Top module: `miner_regs`

## Requirements
- R1: Address 0 is read-only and always reads 0x01000100: interface revision 0x0100 in bits 15:0 and firmware revision 0x0100 in bits 31:16.
- R2: With the string-ID option (default), address 1 reads with bit 0 = 1, bits 23:1 = 0, and bits 31:24 holding one character per read. The characters form the cyclic sequence NUL, then the ID text starting from its first character (default "MINE"), then NUL again. The first read after reset returns NUL, and only reads of address 1 advance the sequence.
- R3: With the numeric-ID option, address 1 reads {ID_NUM, 1'b0}: bit 0 = 0 and bits 31:1 hold the 31-bit number.
- R4: Address 2 reads {result count[31:24], job count[23:16], result depth[15:8], job depth[7:0]}. A write to it with bits 23:16 equal to zero empties the job queue, and a write with bits 31:24 equal to zero empties the result queue. A write with non-zero fields flushes nothing.
- R5: Address 3 reads the engine's current nonce input.
- R6: Address 4 bit 0 reads the inverse of `core_idle`. Writing bit 0 = 0 drives `core_hold` high, writing bit 0 = 1 drives it low, and `core_hold` is 0 after reset.
- R7: Address 5 reads bit 0 = 1 when the job queue is not full and bit 1 = 1 when the result queue is not empty. Both bits track the queue state right after a flush.
- R8: Writing address 5 with bit 2 = 1 copies job pad bits 351:0 into the job queue. Pad word 208 supplies bits 31:0, and the 96 data bits come before the 256 midstate bits. A commit is ignored when the queue is full. Jobs leave on the job stream in commit order.
- R9: Writing address 5 with bit 3 = 1 moves the oldest result into the result pad at words 240..251, where word 240 holds bits 31:0. The result layout is data in bits 95:0, nonce in bits 127:96 and midstate in bits 383:128. A pop when the queue is empty leaves the pad unchanged. `res_ready` is low when the result queue is full.
- R10: Words 208..239 are written and read back as the 1024-bit job pad.
- R11: Reads of unmapped addresses (6..207) and of result pad words 252..255 return 0. Writes to unmapped addresses change no state. Writes to the result pad are ignored.
- R12: `bus_rdata` updates on the clock edge where `bus_re` is high, showing the addressed word as it was before that edge. It holds its value while `bus_re` is low, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus, queues and streams |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| job_valid | output | 1 | Job queue holds an entry |
| job_ready | input | 1 | Dispatcher takes the head job |
| job_data | output | 352 | Head job, data bits low, midstate high |
| res_valid | input | 1 | Result offered |
| res_ready | output | 1 | Result queue has room |
| res_data | input | 384 | Offered result: data, nonce, midstate |
| core_nonce | input | 32 | Engine's current nonce |
| core_idle | input | 1 | Engine is idle |
| core_hold | output | 1 | Request to park the engine |

## Verification
The main instance uses queue depths of 4 and the four-character text "MINE". With these values, both queues fill after a few bus operations, so commits ignored on a full queue and result back-pressure are reached early. The ID sequence also wraps past its NUL after five reads. A second instance shares the bus and uses the numeric-ID option, so the other register-1 layout is exercised too. Random sequences of commits, takes, offers and pops are compared against queue models kept in the bench.

// File: rtl/minereg_pkg.sv
`timescale 1ns/1ps
package minereg_pkg;
  localparam int JOB_BITS  = 352;
  localparam int RES_BITS  = 384;
  localparam int PAD_WORDS = 32;
  localparam int RES_WORDS = RES_BITS / 32;
  localparam int JOB_WORDS = JOB_BITS / 32;

  localparam logic [7:0] A_VER   = 8'd0;
  localparam logic [7:0] A_ID    = 8'd1;
  localparam logic [7:0] A_QUE   = 8'd2;
  localparam logic [7:0] A_NONCE = 8'd3;
  localparam logic [7:0] A_RUN   = 8'd4;
  localparam logic [7:0] A_CTL   = 8'd5;
  localparam logic [7:0] A_JPAD  = 8'd208;
  localparam logic [7:0] A_RPAD  = 8'd240;

  localparam logic [15:0] IF_REV = 16'h0100;
  localparam logic [15:0] FW_REV = 16'h0100;
endpackage

// File: rtl/mr_fifo.sv
`timescale 1ns/1ps
module mr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  assert_full_push_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> count == CW'(DEPTH));
endmodule

// File: rtl/mr_id_src.sv
`timescale 1ns/1ps
module mr_id_src #(
  parameter bit          IS_STRING = 1'b1,
  parameter logic [30:0] NUM_ID    = 31'h0,
  parameter int          LEN       = 4,
  parameter logic [8*LEN-1:0] TEXT = 32'h4D494E45
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  output logic [31:0] value
);
  localparam int PW = $clog2(LEN+1);
  logic [PW-1:0] pos;
  logic [7:0]    ch;

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else if (advance && IS_STRING) pos <= (pos == PW'(LEN)) ? '0 : pos + PW'(1);
  end

  always_comb begin
    ch = 8'h00;
    for (int k = 1; k <= LEN; k++)
      if (pos == PW'(k)) ch = TEXT[8*(LEN-k) +: 8];
  end

  assign value = IS_STRING ? {ch, 23'd0, 1'b1} : {NUM_ID, 1'b0};

  assert_nul_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && IS_STRING && pos == PW'(LEN)) |=> pos == '0);
endmodule

// File: rtl/miner_regs.sv
`timescale 1ns/1ps
module miner_regs
  import minereg_pkg::*;
#(
  parameter int          JOB_DEPTH = 4,
  parameter int          RES_DEPTH = 4,
  parameter bit          ID_IS_STRING = 1'b1,
  parameter logic [30:0] ID_NUM    = 31'h0000_0001,
  parameter int          ID_LEN    = 4,
  parameter logic [8*ID_LEN-1:0] ID_TEXT = 32'h4D494E45
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  output logic [31:0]         bus_rdata,
  output logic                job_valid,
  input  logic                job_ready,
  output logic [JOB_BITS-1:0] job_data,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [RES_BITS-1:0] res_data,
  input  logic [31:0]         core_nonce,
  input  logic                core_idle,
  output logic                core_hold
);
  localparam int JCW = $clog2(JOB_DEPTH+1);
  localparam int RCW = $clog2(RES_DEPTH+1);

  logic [31:0]         jpad [PAD_WORDS];
  logic [RES_BITS-1:0] rpad;
  logic [JOB_BITS-1:0] job_in;
  logic [RES_BITS-1:0] res_head;
  logic [JCW-1:0]      j_cnt;
  logic [RCW-1:0]      r_cnt;
  logic                j_full, j_empty, r_full, r_empty;
  logic                in_jpad, in_rpad, ctl_wr, que_wr;
  logic                commit, take_res, flush_j, flush_r;
  logic [4:0]          jidx;
  logic [3:0]          ridx;
  logic [31:0]         id_word, rd_next;

  assign in_jpad = (bus_addr >= A_JPAD) && (bus_addr < A_RPAD);
  assign in_rpad = (bus_addr >= A_RPAD);
  assign jidx    = 5'(bus_addr - A_JPAD);
  assign ridx    = bus_addr[3:0];
  assign ctl_wr  = bus_we && (bus_addr == A_CTL);
  assign que_wr  = bus_we && (bus_addr == A_QUE);
  assign commit  = ctl_wr && bus_wdata[2];
  assign take_res = ctl_wr && bus_wdata[3];
  assign flush_j = que_wr && (bus_wdata[23:16] == 8'd0);
  assign flush_r = que_wr && (bus_wdata[31:24] == 8'd0);

  generate
    for (genvar g = 0; g < JOB_WORDS; g++) begin : g_jobpack
      assign job_in[32*g +: 32] = jpad[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAD_WORDS; i++) jpad[i] <= '0;
    end else if (bus_we && in_jpad) begin
      jpad[jidx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 rpad <= '0;
    else if (take_res && !r_empty) rpad <= res_head;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          core_hold <= 1'b0;
    else if (bus_we && bus_addr == A_RUN) core_hold <= !bus_wdata[0];
  end

  mr_fifo #(.W(JOB_BITS), .DEPTH(JOB_DEPTH)) u_jobq (
    .clk(clk), .rst_n(rst_n), .flush(flush_j),
    .push(commit), .push_data(job_in),
    .pop(job_valid && job_ready), .head(job_data),
    .count(j_cnt), .full(j_full), .empty(j_empty));

  mr_fifo #(.W(RES_BITS), .DEPTH(RES_DEPTH)) u_resq (
    .clk(clk), .rst_n(rst_n), .flush(flush_r),
    .push(res_valid && res_ready), .push_data(res_data),
    .pop(take_res), .head(res_head),
    .count(r_cnt), .full(r_full), .empty(r_empty));

  assign job_valid = !j_empty;
  assign res_ready = !r_full;

  mr_id_src #(.IS_STRING(ID_IS_STRING), .NUM_ID(ID_NUM), .LEN(ID_LEN), .TEXT(ID_TEXT)) u_id (
    .clk(clk), .rst_n(rst_n),
    .advance(bus_re && bus_addr == A_ID),
    .value(id_word));

  always_comb begin
    rd_next = '0;
    if (in_jpad) begin
      rd_next = jpad[jidx];
    end else if (in_rpad) begin
      if (int'(ridx) < RES_WORDS) rd_next = rpad[32*int'(ridx) +: 32];
    end else begin
      case (bus_addr)
        A_VER:   rd_next = {FW_REV, IF_REV};
        A_ID:    rd_next = id_word;
        A_QUE:   rd_next = {8'(r_cnt), 8'(j_cnt), 8'(RES_DEPTH), 8'(JOB_DEPTH)};
        A_NONCE: rd_next = core_nonce;
        A_RUN:   rd_next = {31'd0, !core_idle};
        A_CTL:   rd_next = {30'd0, !r_empty, !j_full};
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_VER) |=> bus_rdata == 32'h0100_0100);
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_RUN) |=> $stable(core_hold));
  assert_pad_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_res && !r_empty) |=> $stable(rpad));
endmodule

// File: tb/miner_regs_tb.sv
`timescale 1ns/1ps
module miner_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata, rdata_num;
  logic job_valid, job_ready = 1'b0;
  logic [351:0] job_data;
  logic res_valid = 1'b0, res_ready;
  logic [383:0] res_data = '0;
  logic [31:0] core_nonce = '0;
  logic core_idle = 1'b1;
  logic core_hold;
  logic jv2, rr2, ch2;
  logic [351:0] jd2;

  int checks = 0, fails = 0;
  logic [31:0] mpad [32];
  logic [351:0] jq [$];
  logic [383:0] rq [$];
  logic [383:0] mres;

  always #2.5 clk = ~clk;

  miner_regs u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .job_valid(job_valid),
    .job_ready(job_ready), .job_data(job_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .core_nonce(core_nonce), .core_idle(core_idle), .core_hold(core_hold));

  miner_regs #(.ID_IS_STRING(1'b0), .ID_NUM(31'h0123_4567)) u_dut_num (.clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(rdata_num), .job_valid(jv2), .job_ready(1'b0), .job_data(jd2),
    .res_valid(1'b0), .res_ready(rr2), .res_data(res_data), .core_nonce(core_nonce),
    .core_idle(core_idle), .core_hold(ch2));

  task automatic chk(input string req, input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic padwr(input int i, input logic [31:0] d);
    wr(8'(208 + i), d); mpad[i] = d;
  endtask

  function automatic logic [351:0] job_of();
    logic [351:0] j;
    for (int i = 0; i < 11; i++) j[32*i +: 32] = mpad[i];
    return j;
  endfunction

  task automatic commit_job();
    wr(8'd5, 32'h4);
    if (jq.size() < 4) jq.push_back(job_of());
  endtask

  task automatic take_job();
    @(negedge clk);
    chk("R8 job_valid", {383'd0, job_valid}, {383'd0, jq.size() != 0});
    if (job_valid) begin
      chk("R8 job order/data", {32'd0, job_data}, {32'd0, jq.pop_front()});
      job_ready = 1'b1;
      @(negedge clk); job_ready = 1'b0;
    end
  endtask

  task automatic offer_res(input logic [383:0] d);
    @(negedge clk); res_valid = 1'b1; res_data = d;
    chk("R9 res_ready", {383'd0, res_ready}, {383'd0, rq.size() < 4});
    if (rq.size() < 4) rq.push_back(d);
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic pop_res();
    logic [31:0] v;
    wr(8'd5, 32'h8);
    if (rq.size() != 0) mres = rq.pop_front();
    for (int i = 0; i < 16; i++) begin
      rd(8'(240 + i), v);
      chk("R9 result pad", {352'd0, v}, {352'd0, (i < 12) ? mres[32*i +: 32] : 32'd0});
    end
  endtask

  function automatic logic [383:0] rnd_res();
    logic [383:0] r;
    for (int i = 0; i < 12; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk_counts(input string req);
    logic [31:0] v;
    rd(8'd2, v);
    chk(req, {352'd0, v}, {352'd0, 8'(rq.size()), 8'(jq.size()), 8'd4, 8'd4});
    rd(8'd5, v);
    chk("R7 readiness", {352'd0, v}, {352'd0, 30'd0, rq.size() != 0, jq.size() < 4});
  endtask

  initial begin
    logic [31:0] v, n;
    logic [7:0] idseq [6];
    void'($urandom(32'd1357));
    mres = '0;
    for (int i = 0; i < 32; i++) mpad[i] = '0;
    idseq[0] = 8'h00; idseq[1] = "M"; idseq[2] = "I"; idseq[3] = "N"; idseq[4] = "E"; idseq[5] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset rdata", {352'd0, bus_rdata}, '0);
    chk("R6 reset hold", {383'd0, core_hold}, '0);
    chk_counts("R4 reset counts");

    rd(8'd0, v); chk("R1 version", {352'd0, v}, {352'd0, 32'h0100_0100});
    wr(8'd0, 32'hFFFF_FFFF);
    rd(8'd0, v); chk("R1 version after write", {352'd0, v}, {352'd0, 32'h0100_0100});

    for (int i = 0; i < 7; i++) begin
      rd(8'd1, v);
      chk("R2 id string", {352'd0, v}, {352'd0, idseq[i % 5], 24'd1});
      chk("R3 numeric id", {352'd0, rdata_num}, {352'd0, 32'h0246_8ACE});
    end

    n = $urandom; core_nonce = n;
    rd(8'd3, v); chk("R5 nonce", {352'd0, v}, {352'd0, n});

    core_idle = 1'b0;
    rd(8'd4, v); chk("R6 not idle", {352'd0, v}, {352'd0, 32'd1});
    core_idle = 1'b1;
    rd(8'd4, v); chk("R6 idle", {352'd0, v}, '0);
    wr(8'd4, 32'd0); chk("R6 force idle", {383'd0, core_hold}, {383'd0, 1'b1});
    wr(8'd4, 32'd1); chk("R6 release", {383'd0, core_hold}, '0);

    for (int i = 0; i < 32; i++) padwr(i, $urandom);
    for (int i = 0; i < 32; i++) begin
      rd(8'(208 + i), v); chk("R10 pad readback", {352'd0, v}, {352'd0, mpad[i]});
    end

    for (int k = 0; k < 5; k++) begin
      padwr(0, $urandom); padwr(10, $urandom);
      commit_job();
    end
    chk_counts("R8 full job queue");
    for (int k = 0; k < 5; k++) take_job();

    for (int k = 0; k < 5; k++) offer_res(rnd_res());
    chk_counts("R9 full result queue");
    for (int k = 0; k < 5; k++) pop_res();

    commit_job(); commit_job(); offer_res(rnd_res()); offer_res(rnd_res());
    wr(8'd2, 32'h0101_0000);
    chk_counts("R4 no flush on non-zero");
    wr(8'd2, 32'h0100_0000);
    jq.delete(); chk_counts("R4 job flush");
    wr(8'd2, 32'h0000_0000);
    rq.delete(); chk_counts("R4 result flush");

    rd(8'd6, v);   chk("R11 unmapped read", {352'd0, v}, '0);
    rd(8'd100, v); chk("R11 unmapped read", {352'd0, v}, '0);
    wr(8'd100, 32'hDEAD_BEEF); wr(8'd7, 32'h4);
    wr(8'd241, 32'hFFFF_FFFF);
    chk_counts("R11 unmapped write");
    rd(8'd208, v); chk("R11 pad untouched", {352'd0, v}, {352'd0, mpad[0]});
    rd(8'd241, v); chk("R11 result pad write ignored", {352'd0, v}, {352'd0, mres[63:32]});

    rd(8'd0, v);
    @(negedge clk); bus_addr = 8'd3; core_nonce = ~core_nonce;
    @(negedge clk);
    chk("R12 rdata holds", {352'd0, bus_rdata}, {352'd0, 32'h0100_0100});

    for (int it = 0; it < 60; it++) begin
      case ($urandom % 4)
        0: begin padwr($urandom % 11, $urandom); commit_job(); end
        1: take_job();
        2: offer_res(rnd_res());
        default: pop_res();
      endcase
      chk_counts("R4 random counts");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule